// File: doc/BRIEF.md
# Strided DMA Address Generator

This block produces the byte address for one side (read side or write side) of a DMA transfer. A load pulse captures a start address, a total byte count and a packed 32-bit configuration word. Each accepted step strobe, one per completed data beat, moves the address to the next beat. The word sets the beat width, the address movement and a two-level block/stride pattern.

The address can move in four ways. It can rise, fall or stay fixed, or it can rise inside an aligned window and wrap at the window's edge. When the block field is non-zero, the generator counts the bytes moved in the current block. When a block is complete, the next address is the start of that block plus the stride, and a one-cycle block-end flag is raised. The remaining byte count falls with every beat. A done flag is set when the count reaches zero, and further strobes are then ignored until the next load. The data path, the bus protocol and descriptor fetching are handled elsewhere.

Top module: `stride_addr_gen`

## Requirements
- R1: During and after reset, before any load, `addr` is 0, `block_end` is 0, `done` is 1 and `xfer_bytes` is 1.
- R2: A `load` sampled at a clock edge makes `addr` equal to `base_addr` after that edge. It clears the block byte counter, and it sets `done` exactly when `byte_count` is 0. When `load` and `step` arrive together, the load wins.
- R3: `xfer_bytes` equals 1, 2, 4 or 8 when the loaded size code `cfg_word[31:30]` is 0, 1, 2 or 3.
- R4: Movement code `cfg_word[29:28]` = 0 (rising): each accepted step adds `xfer_bytes` to `addr`.
- R5: Movement code 1 (falling): each accepted step subtracts `xfer_bytes` from `addr`.
- R6: Movement code 2 (fixed): an accepted step that does not end a block leaves `addr` unchanged.
- R7: Movement code 3 (wrapping): the window is `BURST_BEATS * xfer_bytes` bytes and is aligned to its own size. Each step adds `xfer_bytes` to the address within the window, modulo the window size, and leaves the bits above the window unchanged.
- R8: With block field `cfg_word[27:14]` non-zero, a step that brings the bytes moved in the current block to at least the block field ends the block. In that case the next `addr` is the start address of that block plus the stride `cfg_word[13:0]`, and that address becomes the new block start. This takes the place of the movement rule.
- R9: `block_end` is 1 for exactly the cycle after the edge at which a block-ending step was accepted, and 0 otherwise.
- R10: A block field of 0 disables the block logic: there are no stride jumps and no `block_end`.
- R11: Each accepted step lowers the remaining count by `xfer_bytes`, stopping at 0. `done` rises after the edge at which the count reaches 0.
- R12: While `done` is 1, `step` has no effect on `addr`, `block_end` or `done` until the next `load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Capture base address, count and configuration |
| base_addr | input | ADDR_W | Start address for the transfer |
| byte_count | input | CNT_W | Total bytes for the transfer |
| cfg_word | input | 32 | Size [31:30], movement [29:28], block [27:14], stride [13:0] |
| step | input | 1 | One beat accepted by the data path |
| addr | output | ADDR_W | Current byte address |
| xfer_bytes | output | 4 | Bytes per beat |
| block_end | output | 1 | One-cycle pulse after a block completes |
| done | output | 1 | Byte count used up |

## Verification
`addr`, `block_end` and `done` are registered. The effect of a load or step sampled at rising edge N is therefore due one edge later: it is visible from just after edge N until edge N+1. `xfer_bytes` follows the size code latched at the load edge, so it is also due one edge later. The bench drives inputs on falling edges and advances a behavioural model on each rising edge. On every falling edge it compares all four outputs with that model, which puts the sampling point half a cycle after the edge at which each result becomes due.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam int FIELD_W = 14;

  typedef enum logic [1:0] {
    MV_RISE  = 2'd0,
    MV_FALL  = 2'd1,
    MV_FIXED = 2'd2,
    MV_WRAP  = 2'd3
  } move_e;

  typedef struct packed {
    logic [1:0]         size_code;
    move_e              mode;
    logic [FIELD_W-1:0] blk_bytes;
    logic [FIELD_W-1:0] stride;
  } sag_cfg_t;

  function automatic logic [3:0] beat_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/sag_count_track.sv
module sag_count_track #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step_ok,
  input  logic [CNT_W-1:0] count_in,
  input  logic [3:0]       beat,
  output logic             done
);
  logic [CNT_W-1:0] remaining;
  logic [CNT_W-1:0] beat_w;
  logic [CNT_W-1:0] rem_next;
  logic             hits_zero;

  assign beat_w    = CNT_W'(beat);
  assign hits_zero = (remaining <= beat_w);
  assign rem_next  = hits_zero ? '0 : remaining - beat_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
      done      <= 1'b1;
    end else if (load) begin
      remaining <= count_in;
      done      <= (count_in == '0);
    end else if (step_ok) begin
      remaining <= rem_next;
      done      <= hits_zero;
    end
  end

  // the count only falls between loads
  assert_count_falls_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> remaining <= $past(remaining));
  // done is only left by a load
  assert_done_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);
endmodule

// File: rtl/sag_addr_path.sv
module sag_addr_path
  import sag_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BURST_BEATS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step_ok,
  input  logic [ADDR_W-1:0]  base,
  input  move_e              mode,
  input  logic [3:0]         beat,
  input  logic [FIELD_W-1:0] blk_bytes,
  input  logic [FIELD_W-1:0] stride,
  output logic [ADDR_W-1:0]  addr,
  output logic               block_end
);
  localparam int SUM_W = FIELD_W + 2;

  logic [ADDR_W-1:0] blk_start;
  logic [SUM_W-1:0]  blk_cnt;
  logic [SUM_W-1:0]  blk_sum;
  logic              boundary;
  logic [ADDR_W-1:0] moved_addr;
  logic [ADDR_W-1:0] jump_addr;

  function automatic logic [ADDR_W-1:0] wrap_step(input logic [ADDR_W-1:0] a,
                                                   input logic [3:0] b);
    logic [ADDR_W-1:0] win_mask;
    win_mask = ADDR_W'(BURST_BEATS) * ADDR_W'(b) - ADDR_W'(1);
    return (a & ~win_mask) | ((a + ADDR_W'(b)) & win_mask);
  endfunction

  function automatic logic [ADDR_W-1:0] move_step(input logic [ADDR_W-1:0] a,
                                                   input move_e m,
                                                   input logic [3:0] b);
    case (m)
      MV_RISE:  return a + ADDR_W'(b);
      MV_FALL:  return a - ADDR_W'(b);
      MV_FIXED: return a;
      default:  return wrap_step(a, b);
    endcase
  endfunction

  assign blk_sum    = blk_cnt + SUM_W'(beat);
  assign boundary   = (blk_bytes != '0) && (blk_sum >= SUM_W'(blk_bytes));
  assign moved_addr = move_step(addr, mode, beat);
  assign jump_addr  = blk_start + ADDR_W'(stride);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr      <= '0;
      blk_start <= '0;
      blk_cnt   <= '0;
      block_end <= 1'b0;
    end else begin
      block_end <= 1'b0;
      if (load) begin
        addr      <= base;
        blk_start <= base;
        blk_cnt   <= '0;
      end else if (step_ok) begin
        if (boundary) begin
          addr      <= jump_addr;
          blk_start <= jump_addr;
          blk_cnt   <= '0;
          block_end <= 1'b1;
        end else begin
          addr    <= moved_addr;
          blk_cnt <= blk_sum;
        end
      end
    end
  end

  assert_fixed_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && !load && mode == MV_FIXED && !boundary) |=> $stable(addr));
  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(block_end) |-> $past(step_ok) && !$past(load));
  assert_no_jump_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_bytes == '0) |=> !block_end);
  assert_jump_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && !load && boundary) |=> addr == blk_start);
endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen
  import sag_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 22,
  parameter int BURST_BEATS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [31:0]       cfg_word,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [3:0]        xfer_bytes,
  output logic              block_end,
  output logic              done
);
  sag_cfg_t cfg_q;
  logic     step_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (load) cfg_q <= sag_cfg_t'(cfg_word);
  end

  assign step_ok    = step && !done && !load;
  assign xfer_bytes = beat_bytes(cfg_q.size_code);

  sag_addr_path #(.ADDR_W(ADDR_W), .BURST_BEATS(BURST_BEATS)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step_ok  (step_ok),
    .base     (base_addr),
    .mode     (cfg_q.mode),
    .beat     (xfer_bytes),
    .blk_bytes(cfg_q.blk_bytes),
    .stride   (cfg_q.stride),
    .addr     (addr),
    .block_end(block_end)
  );

  sag_count_track #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step_ok (step_ok),
    .count_in(byte_count),
    .beat    (xfer_bytes),
    .done    (done)
  );

  assert_load_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr == $past(base_addr));
  assert_size_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> xfer_bytes == (4'd1 << $past(cfg_word[31:30])));
  assert_done_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> $stable(addr) && !block_end);
  assert_rise_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !done && !load && !$rose(block_end) && cfg_q.mode == MV_RISE
     && cfg_q.blk_bytes == '0) |=> addr == $past(addr) + ADDR_W'($past(xfer_bytes)));
endmodule

// File: tb/test_stride_addr_gen.sv
module test_stride_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] base_addr = '0;
  logic [21:0] byte_count = '0;
  logic [31:0] cfg_word = '0;
  logic        step = 1'b0;
  logic [31:0] addr;
  logic [3:0]  xfer_bytes;
  logic        block_end;
  logic        done;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;

  stride_addr_gen i_stride_addr_gen (
    .clk(clk), .rst_n(rst_n), .load(load), .base_addr(base_addr),
    .byte_count(byte_count), .cfg_word(cfg_word), .step(step),
    .addr(addr), .xfer_bytes(xfer_bytes), .block_end(block_end), .done(done)
  );

  always #2 clk = ~clk;

  // behavioural reference
  logic [31:0] m_addr = '0, m_start = '0;
  int m_left = 0, m_blk = 0, m_rem = 0, m_size = 1, m_mode = 0, m_str = 0;
  bit m_done = 1'b1, m_bend = 1'b0;
  string m_tag = "R1";

  always @(posedge clk) begin
    int win, off;
    m_bend = 1'b0;
    if (!rst_n) begin
      m_addr = '0; m_start = '0; m_rem = 0; m_done = 1'b1; m_size = 1;
      m_mode = 0; m_blk = 0; m_left = 0; m_str = 0; m_tag = "R1";
    end else if (load) begin
      m_addr = base_addr; m_start = base_addr; m_rem = int'(byte_count);
      m_done = (byte_count == 0); m_size = 1 << cfg_word[31:30];
      m_mode = int'(cfg_word[29:28]); m_blk = int'(cfg_word[27:14]);
      m_str = int'(cfg_word[13:0]); m_left = m_blk; m_tag = "R2";
    end else if (step && !m_done) begin
      m_rem = m_rem - m_size;
      if (m_rem <= 0) begin m_rem = 0; m_done = 1'b1; end
      m_left = m_left - m_size;
      if (m_blk != 0 && m_left <= 0) begin
        m_start = m_start + 32'(m_str); m_addr = m_start;
        m_left = m_blk; m_bend = 1'b1; m_tag = "R8";
      end else begin
        case (m_mode)
          0: begin m_addr = m_addr + 32'(m_size); m_tag = "R4"; end
          1: begin m_addr = m_addr - 32'(m_size); m_tag = "R5"; end
          2: m_tag = "R6";
          default: begin
            win = 4 * m_size;
            off = int'(m_addr % 32'(win));
            m_addr = m_addr - 32'(off) + 32'((off + m_size) % win);
            m_tag = "R7";
          end
        endcase
      end
    end else if (step) m_tag = "R12";
  end

  always @(negedge clk) begin
    cycles++;
    vectors++;
    if (addr !== m_addr) begin
      misses++; $display("FAIL %s addr got %h expected %h", m_tag, addr, m_addr);
    end
    if (xfer_bytes !== 4'(m_size)) begin
      misses++; $display("FAIL R3 xfer_bytes got %0d expected %0d", xfer_bytes, m_size);
    end
    if (block_end !== m_bend) begin
      misses++; $display("FAIL R9 block_end got %b expected %b", block_end, m_bend);
    end
    if (done !== m_done) begin
      misses++; $display("FAIL R11 done got %b expected %b", done, m_done);
    end
    if (cycles > 100000) begin
      misses++; $display("FAIL watchdog got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  function automatic logic [31:0] cfg(int sz, int mv, int blk, int str);
    return {2'(sz), 2'(mv), 14'(blk), 14'(str)};
  endfunction

  task automatic do_load(logic [31:0] b, int cnt, logic [31:0] c);
    @(negedge clk);
    load = 1'b1; base_addr = b; byte_count = 22'(cnt); cfg_word = c; step = 1'b0;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_steps(int n, int gap);
    for (int i = 0; i < n; i++) begin
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  initial begin
    // R1: reset values are compared by the model during reset
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R4, R3: rising, 4-byte beats, no blocks; extra steps hit R12
    do_load(32'h0000_1000, 32, cfg(2, 0, 0, 0));
    run_steps(10, 0);
    // R5, R8, R9: falling, 2-byte beats, 8-byte blocks, stride 0x100
    do_load(32'h0000_4000, 24, cfg(1, 1, 8, 16'h100));
    run_steps(13, 1);
    // R6, R8: fixed, byte beats, 4-byte blocks, stride 0x10
    do_load(32'h0000_0200, 10, cfg(0, 2, 4, 16'h10));
    run_steps(11, 0);
    // R7, R10: wrapping, 4-byte beats, 16-byte window, no blocks
    do_load(32'h0000_2008, 40, cfg(2, 3, 0, 16'h3ff));
    run_steps(11, 0);
    // R7, R8: wrapping with 8-byte beats plus blocks
    do_load(32'hFFFF_FFE8, 64, cfg(3, 3, 16, 16'h40));
    run_steps(9, 2);
    // R2, R12: zero count is done at once and steps are ignored
    do_load(32'h0000_3000, 0, cfg(2, 0, 0, 0));
    run_steps(3, 0);
    // R11: count not a multiple of the beat saturates at zero
    do_load(32'h0000_5000, 5, cfg(3, 0, 0, 0));
    run_steps(3, 0);
    // R2: load wins over a simultaneous step
    do_load(32'h0000_6000, 16, cfg(0, 0, 0, 0));
    run_steps(2, 0);
    @(negedge clk);
    load = 1'b1; step = 1'b1; base_addr = 32'h0000_7000; byte_count = 22'd8;
    cfg_word = cfg(1, 1, 0, 0);
    @(negedge clk);
    load = 1'b0;
    run_steps(5, 0);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule